// File: doc/BRIEF.md
# Management Data Serial Master

This block is the controlling end of a two-wire management link used to configure and query physical-layer devices. It makes the management clock from the system clock with a divider set for each request. It serialises one complete frame per request onto a shared data line, which it drives through separate output, output-enable and input signals so that the tristate pad can sit outside the block. A request gives the wire opcode, a 5-bit port address, a 5-bit register or device-type field and a 16-bit data word. The response is a one-cycle done strobe, with the captured word on reads.

Two frame families are supported. A legacy frame carries the port, the register number and the data in one pass. An extended access uses two frames: an address frame loads a 16-bit register pointer in the selected device, and a later frame reads it, writes it, or reads it and then advances the pointer. The master is the only party that starts traffic or toggles the clock. It knows nothing about the registers behind the link. A caller that issues an extended read-increment sends that opcode and the managed device advances its own pointer.

Top module: `mgmt_ser_master`

## Requirements
- R1: `mdc` is low while idle. While busy it toggles every `clk_div`+1 system clocks, beginning low. `clk_div` is captured when a request is accepted.
- R2: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the frame ends. Requests presented while busy are ignored and leave the frame on the wire unchanged.
- R3: Every frame starts with 32 bit times of logic one driven by the master.
- R4: When `req_ext`=0, the bits after the preamble are start code 01, then `req_op` (01 write, 10 read), `req_port`, `req_reg`, turnaround and 16 data bits. Every field is sent MSB first, one bit per `mdc` period.
- R5: When `req_ext`=1, the start code is 00 and the opcodes are 00 address, 01 write, 11 read and 10 read-with-increment. `req_reg` carries the device type, and `req_data` carries the 16-bit register pointer on address frames.
- R6: On non-read frames the master drives 1 then 0 in the two turnaround bit times.
- R7: On read frames (legacy 10, extended 11 or 10), `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits after turnaround are sampled from `mdio_i` at the rising `mdc` edges, MSB first, and returned on `rsp_data`.
- R8: While busy, `mdio_o` changes only together with a falling `mdc` edge, never while `mdc` is high.
- R9: `rsp_done` is high for exactly one cycle: the cycle in which `busy` falls, 128·(`clk_div`+1) cycles after the first busy cycle. `rsp_data` changes only at that strobe and only for read frames.
- R10: After reset `mdc`=0, `mdio_oe`=0, `mdio_o`=1, `busy`=0, `rsp_done`=0 and `rsp_data`=0. When idle, `mdio_oe` is 0 and `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 8 | Half-period of `mdc` minus one, in system clocks |
| req_valid | input | 1 | Request strobe |
| req_ext | input | 1 | 1 selects the extended frame family |
| req_op | input | 2 | Opcode placed on the wire |
| req_port | input | 5 | Port address |
| req_reg | input | 5 | Register number (legacy) or device type (extended) |
| req_data | input | 16 | Write data or register pointer |
| busy | output | 1 | Frame in progress |
| rsp_done | output | 1 | One-cycle end-of-frame strobe |
| rsp_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench uses the default widths: 32-bit preamble, 5-bit address fields, 16-bit data and an 8-bit divider. It varies `clk_div` across 0, 1, 2 and 3 from frame to frame. A divisor of zero puts a bit transition on every other system clock, where an off-by-one in the edge counting shows up at once. The larger divisors show whether the divisor is captured per request. Frames run back to back with `req_valid` held through the done cycle, and requests arrive mid-frame, which tests the accept and ignore boundary.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] ST_LEGACY  = 2'b01;
  localparam logic [1:0] ST_EXT     = 2'b00;
  localparam logic [1:0] TA_DRIVEN  = 2'b10;
  localparam logic [1:0] TA_RELEASE = 2'b11;
  localparam logic [1:0] OP_LEG_RD  = 2'b10;
endpackage

// File: rtl/mgmt_clk_gen.sv
module mgmt_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= '0;
    end else if (load) begin
      cnt <= '0;
      lim <= div_in;
    end else if (run) begin
      if (cnt == lim) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == lim);
endmodule

// File: rtl/mgmt_frame_fmt.sv
module mgmt_frame_fmt
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  localparam int FRAME_W = PRE_LEN + 6 + 2*ADDR_W + DATA_W
) (
  input  logic              ext,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] port,
  input  logic [ADDR_W-1:0] regf,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_W-1:0] frame,
  output logic               is_read
);
  logic [1:0] st;
  logic [1:0] ta;

  always_comb begin
    if (ext) is_read = op[1];
    else     is_read = (op == OP_LEG_RD);
    st    = ext ? ST_EXT : ST_LEGACY;
    ta    = is_read ? TA_RELEASE : TA_DRIVEN;
    frame = {{PRE_LEN{1'b1}}, st, op, port, regf, ta, data};
  end
endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (en)    word <= {word[DATA_W-2:0], bit_in};
  end
endmodule

// File: rtl/mgmt_ser_master.sv
module mgmt_ser_master #(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  input  logic              req_ext,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_port,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_W  = PRE_LEN + 6 + 2*ADDR_W + DATA_W;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int TA_POS   = PRE_LEN + 4 + 2*ADDR_W;
  localparam int DAT_POS  = TA_POS + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(TA_POS - 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DAT_POS);

  logic [FRAME_W-1:0] frame_new;
  logic               read_new;
  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               rd_q;
  logic               start;
  logic               tick;
  logic               cap_en;
  logic [DATA_W-1:0]  rx_word;

  assign start  = req_valid && !busy;
  assign cap_en = tick && !mdc && rd_q && (idx >= DAT_IDX);

  mgmt_frame_fmt #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fmt (
    .ext(req_ext), .op(req_op), .port(req_port), .regf(req_reg),
    .data(req_data), .frame(frame_new), .is_read(read_new)
  );

  mgmt_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .load(start), .run(busy),
    .div_in(clk_div), .tick(tick)
  );

  mgmt_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(start), .en(cap_en),
    .bit_in(mdio_i), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rsp_done <= 1'b0;
      rsp_data <= '0;
      mdc      <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      shreg    <= '0;
      idx      <= '0;
      rd_q     <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          shreg   <= frame_new;
          idx     <= '0;
          rd_q    <= read_new;
          mdc     <= 1'b0;
          mdio_o  <= frame_new[FRAME_W-1];
          mdio_oe <= 1'b1;
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          mdc <= 1'b0;
          if (idx == LAST_IDX) begin
            busy     <= 1'b0;
            rsp_done <= 1'b1;
            mdio_oe  <= 1'b0;
            mdio_o   <= 1'b1;
            if (rd_q) rsp_data <= rx_word;
          end else begin
            idx     <= idx + 1'b1;
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            mdio_o  <= shreg[FRAME_W-2];
            mdio_oe <= !(rd_q && (idx >= REL_IDX));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_ser_master_chk.sv
module mgmt_ser_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R8
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> (!mdc && $past(mdc)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_done);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_done |-> $stable(rsp_data));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && mdio_o));
endmodule

bind mgmt_ser_master mgmt_ser_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_done(rsp_done),
  .rsp_data(rsp_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mgmt_ser_master.sv
`timescale 1ns/1ps
module test_mgmt_ser_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ext = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_port = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_data = '0;
  logic        busy, rsp_done, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_data;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  mgmt_ser_master i_mgmt_ser_master (
    .clk(clk), .rst(rst), .clk_div(clk_div), .req_valid(req_valid),
    .req_ext(req_ext), .req_op(req_op), .req_port(req_port),
    .req_reg(req_reg), .req_data(req_data), .busy(busy),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Behavioural reference
  bit          m_act = 0;
  bit          m_done = 0;
  bit          m_rd = 0;
  bit          m_ext = 0;
  int          m_t = 0;
  int          m_h = 1;
  logic [63:0] m_frame = '0;
  logic [15:0] m_rsp = '0;
  logic [15:0] dev_word = 16'hA5C3;
  logic [15:0] m_dev = '0;
  logic        prev_mdc = 1'b0;
  logic        prev_mdo = 1'b1;
  bit          prev_busy = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_act = 0; m_done = 0; m_rsp = '0; m_t = 0;
    end else begin
      bit was_act;
      was_act = m_act;
      m_done = 0;
      if (was_act) begin
        m_t++;
        if (m_t == 128 * m_h) begin
          m_act = 0;
          m_done = 1;
          if (m_rd) m_rsp = m_dev;
        end
      end else if (req_valid) begin
        m_act = 1;
        m_t = 0;
        m_h = int'(clk_div) + 1;
        m_ext = req_ext;
        m_rd = req_ext ? req_op[1] : (req_op == 2'b10);
        m_dev = dev_word;
        m_frame = {32'hFFFF_FFFF, (req_ext ? 2'b00 : 2'b01), req_op,
                   req_port, req_reg, (m_rd ? 2'b11 : 2'b10), req_data};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int k;
      bit e_mdc, e_oe;
      string rq;
      k = m_t / (2 * m_h);
      e_mdc = m_act && (((m_t / m_h) % 2) == 1);
      e_oe = m_act && !(m_rd && k >= 46);
      chk(busy == m_act, "R2", "busy", busy, m_act);
      chk(mdc == e_mdc, "R1", "mdc", mdc, e_mdc);
      chk(mdio_oe == e_oe, "R7", "mdio_oe", mdio_oe, e_oe);
      chk(rsp_done == m_done, "R9", "rsp_done", rsp_done, m_done);
      chk(rsp_data == m_rsp, "R7", "rsp_data", rsp_data, m_rsp);
      if (m_act && e_oe) begin
        if (k < 32) rq = "R3";
        else if (k >= 46 && k < 48) rq = "R6";
        else if (m_ext) rq = "R5";
        else rq = "R4";
        chk(mdio_o == m_frame[63-k], rq, "mdio_o", mdio_o, m_frame[63-k]);
      end else if (!m_act) begin
        chk(mdio_o == 1'b1, "R10", "idle mdio_o", mdio_o, 1);
      end
      if (prev_busy && busy && prev_mdc && mdc)
        chk(mdio_o == prev_mdo, "R8", "mdio_o while mdc high", mdio_o, prev_mdo);
      // device model drives the line during read frames
      if (m_act && m_rd && k == 47) mdio_i = 1'b0;
      else if (m_act && m_rd && k >= 48) mdio_i = m_dev[63-k];
      else mdio_i = 1'b1;
      prev_mdc = mdc;
      prev_mdo = mdio_o;
      prev_busy = busy;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic send(input bit ext, input logic [1:0] op, input logic [4:0] port,
                      input logic [4:0] rg, input logic [15:0] d,
                      input logic [7:0] dv, input logic [15:0] dw);
    @(posedge clk); #1;
    dev_word = dw;
    clk_div = dv; req_ext = ext; req_op = op; req_port = port;
    req_reg = rg; req_data = d; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    clk_div = 8'd7;
    wait (m_done == 1);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(mdc == 0 && mdio_oe == 0 && mdio_o == 1 && busy == 0 && rsp_done == 0 &&
        rsp_data == 0, "R10", "reset state", {mdc, mdio_oe, mdio_o, busy, rsp_done}, 5'b00100);
    // R4 legacy write and read
    send(0, 2'b01, 5'h11, 5'h0A, 16'hBEEF, 8'd0, 16'h0000);
    send(0, 2'b10, 5'h03, 5'h1F, 16'h0000, 8'd1, 16'h9C35);
    // R5 extended address, write, read, read-increment
    send(1, 2'b00, 5'h1E, 5'h01, 16'h8001, 8'd2, 16'h0000);
    send(1, 2'b01, 5'h1E, 5'h01, 16'h1234, 8'd0, 16'h0000);
    send(1, 2'b11, 5'h1E, 5'h01, 16'h0000, 8'd3, 16'h5AF0);
    send(1, 2'b10, 5'h00, 5'h07, 16'h0000, 8'd1, 16'hFFFE);
    // R2 request mid-frame is ignored; R9 write leaves rsp_data unchanged
    @(posedge clk); #1;
    dev_word = 16'h0001;
    clk_div = 8'd1; req_ext = 0; req_op = 2'b01; req_port = 5'h05;
    req_reg = 5'h02; req_data = 16'h0F0F; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (100) @(posedge clk);
    #1;
    req_ext = 1; req_op = 2'b11; req_port = 5'h1A; req_data = 16'hFFFF;
    clk_div = 8'd0; req_valid = 1'b1;
    repeat (20) @(posedge clk);
    #1 req_valid = 1'b0;
    wait (m_done == 1);
    // R2 back-to-back: valid held through the done cycle
    @(posedge clk); #1;
    dev_word = 16'h8421;
    clk_div = 8'd0; req_ext = 0; req_op = 2'b10; req_port = 5'h09;
    req_reg = 5'h04; req_valid = 1'b1;
    wait (m_done == 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait (m_done == 1);
    repeat (4) @(posedge clk);
    #1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule